// File: doc/BRIEF.md
# Monitor Security Unlock Controller

This block guards the protected memory of a chip that starts in a debug monitor. After a power-on reset it takes the first eight bytes that a host delivers over a byte-serial receive interface. It compares them in arrival order against an internal bank of eight key bytes. It keeps a running match flag and, after the last key byte, latches the result as an unlock bit in a status byte. Every received byte is echoed after a fixed delay. When the echo of the eighth key byte has gone out, the block raises a one-cycle request for a break character. This request means "ready for commands", so it is raised whether the key matched or not.

While locked, the block does two things. It replaces protected read data with a fixed poison pattern. It turns any instruction fetch from protected memory into an illegal-address reset request. Once the key phase is over, received bytes go straight to the command path and are never compared. The attempt result survives a plain reset. Only a power-on reset reopens the key phase. A mass-erase request sets every stored key byte to 0xFF.

Top module: `mon_unlock`

## Requirements
- R1: After a power-on reset the status byte reads 0x00, and `break_req`, `echo_valid` and `cmd_valid` are low.
- R2: Key byte i, counting received bytes from 0, is compared with bits [8i+7:8i] of the stored key. If all eight bytes are equal, the status byte reads 0x40 (bit 6 set) from the cycle after the eighth byte is accepted.
- R3: If any one of the eight bytes differs, the status byte stays 0x00 after the eighth byte. The result stays latched until the next power-on reset.
- R4: Each accepted byte appears on `echo_data` with `echo_valid` high for exactly one cycle. This happens ECHO_DLY cycles after the cycle in which `rx_valid` was high.
- R5: `break_req` is high for exactly one cycle: the cycle after the echo of the eighth key byte. This holds for both a pass and a fail. It is never high during or after the other key bytes.
- R6: Bytes received after the eighth key byte appear on `cmd_data` with `cmd_valid` in the same cycle. They do not change the status byte.
- R7: With `rd_prot` high, `rd_data` equals `mem_rd_data` when status bit 6 is set, and 0xAD otherwise. With `rd_prot` low, `rd_data` always equals `mem_rd_data`.
- R8: `illegal_rst` is high in the same cycle as `fetch_prot` whenever status bit 6 is clear, and low whenever it is set.
- R9: A pulse on `rst_n` alone keeps the status byte as it was and does not reopen the key phase. Later bytes go to the command path and raise no break request.
- R10: A power-on reset clears the result and the byte position, so a fresh eight-byte attempt is evaluated.
- R11: `erase_req` sets all eight stored key bytes to 0xFF. A key of eight 0xFF bytes sent afterwards sets status bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Plain reset, asynchronous, active low; echo and break only |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| erase_req | input | 1 | Mass-erase request for the stored key |
| echo_valid | output | 1 | Echo byte strobe |
| echo_data | output | 8 | Echoed byte |
| break_req | output | 1 | Request to send a break character |
| cmd_valid | output | 1 | Byte handed to the command path |
| cmd_data | output | 8 | Command byte |
| status | output | 8 | Status byte; bit 6 = unlocked |
| rd_prot | input | 1 | Current read targets protected memory |
| mem_rd_data | input | 8 | Raw memory read data |
| rd_data | output | 8 | Gated read data |
| fetch_prot | input | 1 | Instruction fetch from protected memory |
| illegal_rst | output | 1 | Illegal-address reset request |

## Verification
The bench builds the block with eight key bytes, a stored key whose bytes are all different, and an echo delay of four cycles. The distinct key bytes make any ordering slip in the comparison visible. The delay of four leaves room to check that `break_req` and `echo_valid` stay low in the cycles between a byte and its echo. The bench also checks that the break request sits exactly one cycle behind the last echo. A single power cycle then runs through a failed attempt, a plain reset and post-key command bytes. Further power cycles cover a correct key and a key of all ones after erase.

// File: rtl/mon_unlock_pkg.sv
package mon_unlock_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t POISON_BYTE = 8'hAD;
endpackage

// File: rtl/mon_rst_sync.sv
module mon_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/mon_key_check.sv
module mon_key_check
  import mon_unlock_pkg::*;
#(
  parameter int                     KEY_BYTES = 8,
  parameter logic [KEY_BYTES*8-1:0] KEY_INIT  = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_valid,
  input  byte_t rx_data,
  input  logic  erase_req,
  output logic  done_o,
  output logic  pass_o,
  output logic  last_o
);
  localparam int IDX_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_BYTES - 1);

  logic [KEY_BYTES-1:0][7:0] bank_q, bank_d;
  logic [IDX_W-1:0]          idx_q, idx_d;
  logic                      run_q, run_d;
  logic                      done_q, done_d;
  logic                      pass_q, pass_d;
  logic                      accept, byte_eq;

  assign accept  = rx_valid && !done_q;
  assign byte_eq = (rx_data == bank_q[idx_q]);

  always_comb begin
    bank_d = bank_q;
    idx_d  = idx_q;
    run_d  = run_q;
    done_d = done_q;
    pass_d = pass_q;
    if (erase_req) bank_d = '1;
    if (accept) begin
      run_d = run_q & byte_eq;
      if (idx_q == LAST_IDX) begin
        done_d = 1'b1;
        pass_d = run_q & byte_eq;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= KEY_INIT;
      idx_q  <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      bank_q <= bank_d;
      idx_q  <= idx_d;
      run_q  <= run_d;
      done_q <= done_d;
      pass_q <= pass_d;
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
  assign last_o = accept && (idx_q == LAST_IDX);
endmodule

// File: rtl/mon_echo_break.sv
module mon_echo_break
  import mon_unlock_pkg::*;
#(
  parameter int ECHO_DLY = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_valid,
  input  byte_t rx_data,
  input  logic  rx_last,
  output logic  echo_valid,
  output byte_t echo_data,
  output logic  break_req
);
  localparam int CNT_W = (ECHO_DLY > 1) ? $clog2(ECHO_DLY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ECHO_DLY - 1);

  logic             pend_q, pend_d;
  logic             last_q, last_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  byte_t            hold_q, hold_d;
  logic             brk_q, brk_d;
  logic             fire;

  assign fire = pend_q && (cnt_q == '0);

  always_comb begin
    pend_d = pend_q;
    last_d = last_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    brk_d  = fire && last_q;
    if (rx_valid) begin
      pend_d = 1'b1;
      last_d = rx_last;
      cnt_d  = CNT_LOAD;
      hold_d = rx_data;
    end else if (fire) begin
      pend_d = 1'b0;
      last_d = 1'b0;
    end else if (pend_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      last_q <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
      brk_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      last_q <= last_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      brk_q  <= brk_d;
    end
  end

  assign echo_valid = fire;
  assign echo_data  = hold_q;
  assign break_req  = brk_q;
endmodule

// File: rtl/mon_unlock.sv
module mon_unlock
  import mon_unlock_pkg::*;
#(
  parameter int                     KEY_BYTES  = 8,
  parameter logic [KEY_BYTES*8-1:0] KEY_INIT   = 64'h3C96_E17B_5AD2_0F48,
  parameter int                     ECHO_DLY   = 4,
  parameter int                     STATUS_BIT = 6
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       erase_req,
  output logic       echo_valid,
  output logic [7:0] echo_data,
  output logic       break_req,
  output logic       cmd_valid,
  output logic [7:0] cmd_data,
  output logic [7:0] status,
  input  logic       rd_prot,
  input  logic [7:0] mem_rd_data,
  output logic [7:0] rd_data,
  input  logic       fetch_prot,
  output logic       illegal_rst
);
  logic por_sync_n, sys_sync_n;
  logic sec_done, sec_pass, key_last;

  mon_rst_sync u_por_sync (.clk(clk), .arst_n(por_n),          .rst_n_o(por_sync_n));
  mon_rst_sync u_sys_sync (.clk(clk), .arst_n(por_n && rst_n), .rst_n_o(sys_sync_n));

  mon_key_check #(.KEY_BYTES(KEY_BYTES), .KEY_INIT(KEY_INIT)) u_key (
    .clk(clk), .rst_n(por_sync_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .erase_req(erase_req), .done_o(sec_done), .pass_o(sec_pass), .last_o(key_last)
  );

  mon_echo_break #(.ECHO_DLY(ECHO_DLY)) u_echo (
    .clk(clk), .rst_n(sys_sync_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(key_last), .echo_valid(echo_valid), .echo_data(echo_data),
    .break_req(break_req)
  );

  assign cmd_valid   = rx_valid && sec_done;
  assign cmd_data    = rx_data;
  assign rd_data     = (rd_prot && !sec_pass) ? POISON_BYTE : mem_rd_data;
  assign illegal_rst = fetch_prot && !sec_pass;

  always_comb begin
    status             = '0;
    status[STATUS_BIT] = sec_pass;
  end
endmodule

// File: rtl/mon_unlock_chk.sv
module mon_unlock_chk (
  input logic clk,
  input logic por_n,
  input logic rst_n,
  input logic done,
  input logic pass,
  input logic break_req,
  input logic cmd_valid,
  input logic rx_valid,
  input logic fetch_prot,
  input logic illegal_rst
);
  assert_pass_needs_done_R2: assert property (@(posedge clk) disable iff (!por_n)
    pass |-> done);

  assert_fail_sticky_R3: assert property (@(posedge clk) disable iff (!por_n)
    (done && !pass) |=> (done && !pass));

  assert_break_after_key_R5: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
    break_req |-> done);

  assert_break_single_R5: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
    break_req |=> !break_req);

  assert_cmd_after_key_R6: assert property (@(posedge clk) disable iff (!por_n)
    cmd_valid |-> (done && rx_valid));

  assert_illegal_locked_R8: assert property (@(posedge clk) disable iff (!por_n)
    illegal_rst |-> (fetch_prot && !pass));

  assert_pass_survives_R9: assert property (@(posedge clk) disable iff (!por_n)
    pass |=> pass);
endmodule

bind mon_unlock mon_unlock_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .done(sec_done), .pass(sec_pass),
  .break_req(break_req), .cmd_valid(cmd_valid), .rx_valid(rx_valid),
  .fetch_prot(fetch_prot), .illegal_rst(illegal_rst)
);

// File: tb/mon_unlock_tb.sv
module mon_unlock_tb;
  localparam int          NB  = 8;
  localparam logic [63:0] KEY = 64'h3C96_E17B_5AD2_0F48;
  localparam int          DLY = 4;

  logic clk, por_n, rst_n, rx_valid, erase_req, rd_prot, fetch_prot;
  logic [7:0] rx_data, mem_rd_data;
  logic echo_valid, break_req, cmd_valid, illegal_rst;
  logic [7:0] echo_data, cmd_data, status, rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  mon_unlock #(.KEY_BYTES(NB), .KEY_INIT(KEY), .ECHO_DLY(DLY), .STATUS_BIT(6)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .erase_req(erase_req), .echo_valid(echo_valid), .echo_data(echo_data),
    .break_req(break_req), .cmd_valid(cmd_valid), .cmd_data(cmd_data), .status(status),
    .rd_prot(rd_prot), .mem_rd_data(mem_rd_data), .rd_data(rd_data),
    .fetch_prot(fetch_prot), .illegal_rst(illegal_rst)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Sends one byte and follows it through echo and break; exp_cmd and exp_brk per R5/R6
  task automatic send_byte(input logic [7:0] b, input logic exp_cmd, input logic exp_brk,
                           input string tag);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    #1;
    check({tag, " R6 cmd_valid"}, cmd_valid, exp_cmd);
    if (exp_cmd) check({tag, " R6 cmd_data"}, cmd_data, b);
    @(negedge clk);
    rx_valid = 1'b0;
    for (int i = 1; i < DLY; i++) begin
      check({tag, " R4 early echo"}, echo_valid, 1'b0);
      check({tag, " R5 early break"}, break_req, 1'b0);
      @(negedge clk);
    end
    check({tag, " R4 echo_valid"}, echo_valid, 1'b1);
    check({tag, " R4 echo_data"}, echo_data, b);
    check({tag, " R5 break with echo"}, break_req, 1'b0);
    @(negedge clk);
    check({tag, " R4 echo one cycle"}, echo_valid, 1'b0);
    check({tag, " R5 break"}, break_req, exp_brk);
    @(negedge clk);
    check({tag, " R5 break one cycle"}, break_req, 1'b0);
  endtask

  task automatic send_key(input logic [63:0] k, input logic exp_cmd, input logic exp_brk,
                          input string tag);
    for (int i = 0; i < NB; i++)
      send_byte(k[8*i +: 8], exp_cmd, exp_brk && (i == NB - 1), tag);
  endtask

  task automatic check_gating(input logic unlocked, input string tag);
    @(negedge clk);
    rd_prot = 1'b1; mem_rd_data = 8'h5C; fetch_prot = 1'b1;
    #1;
    check({tag, " R7 protected read"}, rd_data, unlocked ? 8'h5C : 8'hAD);
    check({tag, " R8 illegal fetch"}, illegal_rst, !unlocked);
    rd_prot = 1'b0; fetch_prot = 1'b0; mem_rd_data = 8'h31;
    #1;
    check({tag, " R7 plain read"}, rd_data, 8'h31);
    check({tag, " R8 no fetch"}, illegal_rst, 1'b0);
  endtask

  task automatic t_reset_state();
    do_por();
    check("R1 status", status, 8'h00);
    check("R1 break", break_req, 1'b0);
    check("R1 echo", echo_valid, 1'b0);
    check("R1 cmd", cmd_valid, 1'b0);
    check_gating(1'b0, "reset");
  endtask

  task automatic t_fail_then_plain_reset();
    logic [63:0] bad;
    bad = KEY;
    bad[8*3 +: 8] = bad[8*3 +: 8] ^ 8'h10;
    send_key(bad, 1'b0, 1'b1, "fail");
    check("R3 status after mismatch", status, 8'h00);
    check_gating(1'b0, "fail");
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 status after plain reset", status, 8'h00);
    send_key(KEY, 1'b1, 1'b0, "R9 retry");
    check("R9 R3 still locked", status, 8'h00);
    check_gating(1'b0, "R9");
  endtask

  task automatic t_pass_after_por();
    do_por();
    check("R10 status cleared", status, 8'h00);
    send_key(KEY, 1'b0, 1'b1, "pass");
    check("R2 R10 status unlocked", status, 8'h40);
    check_gating(1'b1, "pass");
    send_byte(8'h00, 1'b1, 1'b0, "cmd0");
    send_byte(8'hA5, 1'b1, 1'b0, "cmd1");
    check("R6 status unchanged", status, 8'h40);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 pass survives plain reset", status, 8'h40);
  endtask

  task automatic t_erase();
    do_por();
    @(negedge clk);
    erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
    send_key({NB{8'hFF}}, 1'b0, 1'b1, "erase");
    check("R11 blank key unlocks", status, 8'h40);
    do_por();
    send_key(KEY, 1'b0, 1'b1, "noerase");
    check("R2 key restored by power-on", status, 8'h40);
  endtask

  initial begin
    por_n = 1'b0; rst_n = 1'b1; rx_valid = 1'b0; rx_data = '0; erase_req = 1'b0;
    rd_prot = 1'b0; fetch_prot = 1'b0; mem_rd_data = '0;
    t_reset_state();
    t_fail_then_plain_reset();
    t_pass_after_por();
    t_erase();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule